// File: doc/BRIEF.md
# Remote Processor Boot Handshake Sequencer

This block is a host-side controller that brings a remote processor out of its boot ROM and through image authentication by talking to a small memory-mapped mailbox. A single start pulse runs the complete exchange: it publishes the boot image address, waits for the remote boot ROM to report success, and waits for the second-stage loader to report that memory protection is unlocked. It then hands over the metadata address and the code region. After each command it polls the shared loader status register for the value that phase expects.

Each waiting phase has its own timeout, counted in clock cycles as milliseconds times `CYC_PER_MS`. Status registers are read at a fixed interval of `POLL_GAP` idle cycles between reads. The outcome is held on sticky flags (done, bad status, timeout), together with a phase code that names the failing step and the last status word read. All mailbox traffic goes out on a plain single-transfer register bus master port with a ready handshake.

Top module: `mbx_boot_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `bus_req_o`, `done_o`, `err_o` and `timeout_o` are low, and `fail_phase_o` is 0.
- R2: A `start_i` pulse while idle first writes `image_addr_i` to mailbox offset 0x00. It also clears the previous flags, the phase code and `status_o`.
- R3: Boot ROM phase (phase code 1): offset 0x04 is polled. A value of 0 keeps polling, 0x1 advances to the next phase, and any other value ends the sequence with `err_o`.
- R4: Loader phase (phase code 2): offset 0x0C is polled. A value of 0 keeps polling, 0x1 or 0x2 advances, and any other value ends the sequence with `err_o`.
- R5: After the loader phase the block writes, in this order: 0 to offset 0x18, `meta_addr_i` to offset 0x10, and command 0x1 to offset 0x08.
- R6: Metadata phase (phase code 3): offset 0x0C is polled. 0x3 advances. A value with bit 31 set ends the sequence at once with `err_o`. Any other value keeps polling.
- R7: Load phase (phase code 4): the block writes `code_start_i` to 0x14, then command 0x2 to 0x08, then `code_len_i` to 0x18. It then polls 0x0C. 0x4 raises `done_o`, a value with bit 31 set raises `err_o`, and any other value keeps polling.
- R8: A phase whose accepting value has not arrived once its limit of `TMO_x_MS*CYC_PER_MS` cycles has passed ends the sequence with `timeout_o`. The timeout is never declared before that limit, and is decided only on a completed status read.
- R9: Exactly one bus transfer is outstanding at a time. `bus_req_o` stays high, with address, direction and write data stable, until the cycle in which `bus_ready_i` is high.
- R10: At the end of a sequence exactly one of `done_o`, `err_o`, `timeout_o` is high. `fail_phase_o` holds the phase code of the failing step (0 on success). `status_o` holds the last status word read. All of these hold until the next start.
- R11: `start_i` is ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins the boot handshake |
| image_addr_i | input | DW | Boot image address, held stable while busy |
| meta_addr_i | input | DW | Metadata buffer address, held stable while busy |
| code_start_i | input | DW | Code region start address, held stable while busy |
| code_len_i | input | DW | Total code length, held stable while busy |
| bus_req_o | output | 1 | Transfer request, held until ready |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Mailbox register offset |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with ready |
| bus_ready_i | input | 1 | Transfer completes in this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky: final authentication reached |
| err_o | output | 1 | Sticky: unexpected or negative status |
| timeout_o | output | 1 | Sticky: phase limit passed |
| fail_phase_o | output | 3 | Failing phase code 1..4, 0 if none |
| status_o | output | DW | Last status word read |

## Verification
On every cycle the assertions check the bus handshake hold rule, the exclusivity of the three result flags, silence of the bus while idle, and two causal rules. The first is that `done_o` rises only right after a read returned 0x4. The second is that a failure flag rises only right after a completed read and always carries a nonzero phase code. The ordering of the seven writes, which values are accepted or tolerated in each phase, the immediate abort on a negative status, and the lower bound of the timeout window can only be shown by the bench's scenarios. Those scenarios use a scripted mailbox model and a queue of expected writes.

// File: rtl/mbx_boot_pkg.sv
package mbx_boot_pkg;

   // mailbox register offsets (the remote side decodes these)
   localparam logic [7:0] OFS_IMAGE   = 8'h00;
   localparam logic [7:0] OFS_BOOT_ST = 8'h04;
   localparam logic [7:0] OFS_CMD     = 8'h08;
   localparam logic [7:0] OFS_LDR_ST  = 8'h0C;
   localparam logic [7:0] OFS_META    = 8'h10;
   localparam logic [7:0] OFS_CODE    = 8'h14;
   localparam logic [7:0] OFS_LEN     = 8'h18;

   // command words
   localparam int CMD_META = 1;
   localparam int CMD_LOAD = 2;

   // status words
   localparam int ST_BOOT_OK      = 1;
   localparam int ST_UNLOCK       = 1;
   localparam int ST_UNLOCK_SCRUB = 2;
   localparam int ST_META_OK      = 3;
   localparam int ST_LOAD_OK      = 4;

   typedef logic [2:0] phase_t;
   localparam phase_t PH_NONE = 3'd0;
   localparam phase_t PH_BOOT = 3'd1;
   localparam phase_t PH_LDR  = 3'd2;
   localparam phase_t PH_META = 3'd3;
   localparam phase_t PH_LOAD = 3'd4;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_WR_IMG,
      SQ_WR_CLR,
      SQ_WR_META,
      SQ_WR_CMD1,
      SQ_WR_CODE,
      SQ_WR_CMD2,
      SQ_WR_LEN,
      SQ_POLL,
      SQ_GAP
   } seq_state_t;

endpackage

// File: rtl/mbx_cycle_timer.sv
module mbx_cycle_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (en && cnt != TOP) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mbx_bus_port.sv
module mbx_bus_port #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          want,
   input  logic          want_we,
   input  logic [AW-1:0] want_addr,
   input  logic [DW-1:0] want_wdata,
   input  logic          bus_ready_i,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   output logic          xfer_done
);
   assign xfer_done = bus_req_o & bus_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_req_o   <= 1'b0;
         bus_we_o    <= 1'b0;
         bus_addr_o  <= '0;
         bus_wdata_o <= '0;
      end else if (bus_req_o) begin
         if (bus_ready_i) bus_req_o <= 1'b0;
      end else if (want) begin
         bus_req_o   <= 1'b1;
         bus_we_o    <= want_we;
         bus_addr_o  <= want_addr;
         bus_wdata_o <= want_wdata;
      end
   end
endmodule

// File: rtl/mbx_boot_seq.sv
module mbx_boot_seq
   import mbx_boot_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 32,
   parameter int CYC_PER_MS  = 100000,
   parameter int TMO_BOOT_MS = 1000,
   parameter int TMO_LDR_MS  = 5000,
   parameter int TMO_META_MS = 1000,
   parameter int TMO_LOAD_MS = 10000,
   parameter int POLL_GAP    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] image_addr_i,
   input  logic [DW-1:0] meta_addr_i,
   input  logic [DW-1:0] code_start_i,
   input  logic [DW-1:0] code_len_i,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic [DW-1:0] bus_rdata_i,
   input  logic          bus_ready_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          err_o,
   output logic          timeout_o,
   output logic [2:0]    fail_phase_o,
   output logic [DW-1:0] status_o
);
   localparam longint LIM_BOOT = longint'(TMO_BOOT_MS) * CYC_PER_MS;
   localparam longint LIM_LDR  = longint'(TMO_LDR_MS)  * CYC_PER_MS;
   localparam longint LIM_META = longint'(TMO_META_MS) * CYC_PER_MS;
   localparam longint LIM_LOAD = longint'(TMO_LOAD_MS) * CYC_PER_MS;
   localparam longint MAX_A    = (LIM_BOOT > LIM_LDR)  ? LIM_BOOT : LIM_LDR;
   localparam longint MAX_B    = (LIM_META > LIM_LOAD) ? LIM_META : LIM_LOAD;
   localparam longint MAX_LIM  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int     TMO_W    = $clog2(MAX_LIM + 2);
   localparam int     GAP_W    = (POLL_GAP > 1) ? $clog2(POLL_GAP + 1) : 1;
   localparam logic [GAP_W-1:0] GAP_END = GAP_W'(POLL_GAP - 1);

   seq_state_t     state;
   phase_t         phase;
   logic           want, want_we, xfer_done;
   logic [AW-1:0]  want_addr;
   logic [DW-1:0]  want_wdata;
   logic [TMO_W-1:0] elapsed, lim_cur;
   logic [GAP_W-1:0] gap_cnt;
   logic           acc, bad, tmo_hit, poll_done, tmr_clr;

   // ---------------- request fields per state ----------------
   always_comb begin
      want       = 1'b1;
      want_we    = 1'b1;
      want_addr  = '0;
      want_wdata = '0;
      unique case (state)
         SQ_WR_IMG:  begin want_addr = AW'(OFS_IMAGE); want_wdata = image_addr_i; end
         SQ_WR_CLR:  begin want_addr = AW'(OFS_LEN);   want_wdata = '0;           end
         SQ_WR_META: begin want_addr = AW'(OFS_META);  want_wdata = meta_addr_i;  end
         SQ_WR_CMD1: begin want_addr = AW'(OFS_CMD);   want_wdata = DW'(CMD_META); end
         SQ_WR_CODE: begin want_addr = AW'(OFS_CODE);  want_wdata = code_start_i; end
         SQ_WR_CMD2: begin want_addr = AW'(OFS_CMD);   want_wdata = DW'(CMD_LOAD); end
         SQ_WR_LEN:  begin want_addr = AW'(OFS_LEN);   want_wdata = code_len_i;   end
         SQ_POLL: begin
            want_we   = 1'b0;
            want_addr = (phase == PH_BOOT) ? AW'(OFS_BOOT_ST) : AW'(OFS_LDR_ST);
         end
         default: want = 1'b0;
      endcase
   end

   // ---------------- status evaluation per phase ----------------
   always_comb begin
      acc     = 1'b0;
      bad     = 1'b0;
      lim_cur = TMO_W'(LIM_BOOT);
      unique case (phase)
         PH_BOOT: begin
            acc = (bus_rdata_i == DW'(ST_BOOT_OK));
            bad = (bus_rdata_i != '0) && !acc;
         end
         PH_LDR: begin
            acc = (bus_rdata_i == DW'(ST_UNLOCK)) || (bus_rdata_i == DW'(ST_UNLOCK_SCRUB));
            bad = (bus_rdata_i != '0) && !acc;
            lim_cur = TMO_W'(LIM_LDR);
         end
         PH_META: begin
            acc = (bus_rdata_i == DW'(ST_META_OK));
            bad = bus_rdata_i[DW-1];
            lim_cur = TMO_W'(LIM_META);
         end
         PH_LOAD: begin
            acc = (bus_rdata_i == DW'(ST_LOAD_OK));
            bad = bus_rdata_i[DW-1];
            lim_cur = TMO_W'(LIM_LOAD);
         end
         default: ;
      endcase
   end

   assign poll_done = xfer_done && (state == SQ_POLL);
   assign tmo_hit   = (elapsed >= lim_cur);
   assign tmr_clr   = !(state == SQ_POLL || state == SQ_GAP) || (poll_done && acc);
   assign busy_o    = (state != SQ_IDLE);

   // ---------------- sub-blocks ----------------
   mbx_bus_port #(.AW(AW), .DW(DW)) u_port (
      .clk, .rst_n, .want, .want_we, .want_addr, .want_wdata, .bus_ready_i,
      .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o, .xfer_done
   );

   mbx_cycle_timer #(.W(TMO_W)) u_phase_tmr (
      .clk, .rst_n, .clr(tmr_clr), .en(1'b1), .cnt(elapsed)
   );

   mbx_cycle_timer #(.W(GAP_W)) u_gap_tmr (
      .clk, .rst_n, .clr(state != SQ_GAP), .en(1'b1), .cnt(gap_cnt)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= SQ_IDLE;
         phase        <= PH_NONE;
         done_o       <= 1'b0;
         err_o        <= 1'b0;
         timeout_o    <= 1'b0;
         fail_phase_o <= PH_NONE;
         status_o     <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (start_i) begin
               state        <= SQ_WR_IMG;
               phase        <= PH_NONE;
               done_o       <= 1'b0;
               err_o        <= 1'b0;
               timeout_o    <= 1'b0;
               fail_phase_o <= PH_NONE;
               status_o     <= '0;
            end
            SQ_WR_IMG:  if (xfer_done) begin state <= SQ_POLL; phase <= PH_BOOT; end
            SQ_WR_CLR:  if (xfer_done) state <= SQ_WR_META;
            SQ_WR_META: if (xfer_done) state <= SQ_WR_CMD1;
            SQ_WR_CMD1: if (xfer_done) begin state <= SQ_POLL; phase <= PH_META; end
            SQ_WR_CODE: if (xfer_done) state <= SQ_WR_CMD2;
            SQ_WR_CMD2: if (xfer_done) state <= SQ_WR_LEN;
            SQ_WR_LEN:  if (xfer_done) begin state <= SQ_POLL; phase <= PH_LOAD; end
            SQ_POLL: if (xfer_done) begin
               status_o <= bus_rdata_i;
               if (bad) begin
                  state        <= SQ_IDLE;
                  err_o        <= 1'b1;
                  fail_phase_o <= phase;
               end else if (acc) begin
                  unique case (phase)
                     PH_BOOT: phase <= PH_LDR;
                     PH_LDR:  state <= SQ_WR_CLR;
                     PH_META: state <= SQ_WR_CODE;
                     default: begin state <= SQ_IDLE; done_o <= 1'b1; end
                  endcase
               end else if (tmo_hit) begin
                  state        <= SQ_IDLE;
                  timeout_o    <= 1'b1;
                  fail_phase_o <= phase;
               end else begin
                  state <= SQ_GAP;
               end
            end
            SQ_GAP: if (gap_cnt == GAP_END) state <= SQ_POLL;
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mbx_boot_seq_chk.sv
module mbx_boot_seq_chk #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req_o,
   input logic          bus_we_o,
   input logic [AW-1:0] bus_addr_o,
   input logic [DW-1:0] bus_wdata_o,
   input logic [DW-1:0] bus_rdata_i,
   input logic          bus_ready_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          err_o,
   input logic          timeout_o,
   input logic [2:0]    fail_phase_o
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !bus_req_o); // R1

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({done_o, err_o, timeout_o}) <= 1); // R10

   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(bus_req_o && bus_ready_i && !bus_we_o && bus_rdata_i == DW'(4))); // R7

   AST_FAIL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) || $rose(timeout_o) |-> $past(bus_req_o && bus_ready_i && !bus_we_o) && fail_phase_o != 3'd0); // R8
endmodule

bind mbx_boot_seq mbx_boot_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_mbx_boot_seq.sv
`timescale 1ns/1ps
module sim_mbx_boot_seq;
   localparam int AW = 8, DW = 32;
   localparam int CPM = 5, POLL_GAP = 3;
   localparam int LIM_BOOT = 10 * CPM;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [DW-1:0] img = 32'h8000_1000, meta = 32'h8200_0040;
   logic [DW-1:0] cstart = 32'h8400_0000, clen = 32'h0012_3400;
   logic bus_req, bus_we, bus_ready = 1'b0;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata = '0;
   logic busy, done, err, tmo;
   logic [2:0] fphase;
   logic [DW-1:0] status;

   always #4 clk = ~clk;

   mbx_boot_seq #(.AW(AW), .DW(DW), .CYC_PER_MS(CPM), .TMO_BOOT_MS(10), .TMO_LDR_MS(20),
                  .TMO_META_MS(10), .TMO_LOAD_MS(30), .POLL_GAP(POLL_GAP)) u0 (
      .clk, .rst_n, .start_i(start), .image_addr_i(img), .meta_addr_i(meta),
      .code_start_i(cstart), .code_len_i(clen), .bus_req_o(bus_req), .bus_we_o(bus_we),
      .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
      .bus_ready_i(bus_ready), .busy_o(busy), .done_o(done), .err_o(err),
      .timeout_o(tmo), .fail_phase_o(fphase), .status_o(status)
   );

   int n_tests = 0, n_fail = 0;
   logic [7:0]  exp_a[$];
   logic [31:0] exp_d[$];

   // scripted mailbox: N zero reads, then a value
   int boot_zeros, ldr_zeros, meta_zeros, load_zeros;
   logic [31:0] boot_val, ldr_val, meta_val, load_val;
   int stage, boot_reads, ldr_reads, lat;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push_wr(input logic [7:0] a, input logic [31:0] d);
      exp_a.push_back(a);
      exp_d.push_back(d);
   endtask

   // slave model and write monitor (scoreboard pop/compare)
   always @(negedge clk) begin
      if (bus_ready) bus_ready = 1'b0;
      else if (bus_req) begin
         lat++;
         if (lat >= 2) begin
            lat = 0;
            bus_ready = 1'b1;
            if (bus_we) begin
               if (exp_a.size() == 0) chk(0, "R2/R5/R7/R11 unexpected write", {24'h0, bus_addr}, 32'hFFFF_FFFF);
               else begin
                  logic [7:0] ea; logic [31:0] ed;
                  ea = exp_a.pop_front(); ed = exp_d.pop_front();
                  chk(bus_addr == ea, "R2/R5/R7 write offset order", {24'h0, bus_addr}, {24'h0, ea});
                  chk(bus_wdata == ed, "R2/R5/R7 write data", bus_wdata, ed);
               end
               if (bus_addr == 8'h08) begin stage = bus_wdata; ldr_reads = 0; end
            end else if (bus_addr == 8'h04) begin
               boot_reads++;
               bus_rdata = (boot_reads <= boot_zeros) ? 32'h0 : boot_val;
            end else begin
               ldr_reads++;
               if (stage == 0)      bus_rdata = (ldr_reads <= ldr_zeros)  ? 32'h0 : ldr_val;
               else if (stage == 1) bus_rdata = (ldr_reads <= meta_zeros) ? 32'h0 : meta_val;
               else                 bus_rdata = (ldr_reads <= load_zeros) ? 32'h0 : load_val;
            end
         end
      end
   end

   task automatic summary_and_end();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog expired");
         summary_and_end();
      end
   end

   int cyc;
   task automatic run(input int restart_at);
      stage = 0; boot_reads = 0; ldr_reads = 0; lat = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      cyc = 1;
      while (busy && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         start = (cyc == restart_at);   // R11 second pulse mid-run
      end
      start = 1'b0;
   endtask

   task automatic full_writes();
      push_wr(8'h00, img);  push_wr(8'h18, 0); push_wr(8'h10, meta); push_wr(8'h08, 1);
      push_wr(8'h14, cstart); push_wr(8'h08, 2); push_wr(8'h18, clen);
   endtask
   task automatic meta_writes();
      push_wr(8'h00, img); push_wr(8'h18, 0); push_wr(8'h10, meta); push_wr(8'h08, 1);
   endtask

   task automatic ends(input string req, input logic [2:0] flags, input logic [2:0] ph, input logic [31:0] st);
      chk({done, err, tmo} == flags, {req, " result flags"}, {29'h0, done, err, tmo}, {29'h0, flags});
      chk(fphase == ph, {req, " R10 phase code"}, {29'h0, fphase}, {29'h0, ph});
      chk(status == st, {req, " R10 last status"}, status, st);
      chk(exp_a.size() == 0, {req, " missing writes"}, exp_a.size(), 0);
      exp_a.delete(); exp_d.delete();
   endtask

   task automatic cfg(input int bz, input logic [31:0] bv, input int lz, input logic [31:0] lv,
                      input int mz, input logic [31:0] mv, input int dz, input logic [31:0] dv);
      boot_zeros = bz; boot_val = bv; ldr_zeros = lz; ldr_val = lv;
      meta_zeros = mz; meta_val = mv; load_zeros = dz; load_val = dv;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({busy, bus_req, done, err, tmo} == 5'b0, "R1 reset outputs", {27'h0, busy, bus_req, done, err, tmo}, 0);
      chk(fphase == 3'd0, "R1 reset phase", {29'h0, fphase}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // success, loader reports unlocked (R2 R3 R4 R5 R6 R7)
      cfg(2, 1, 1, 1, 3, 3, 2, 4); full_writes(); run(0);
      ends("R7 success", 3'b100, 3'd0, 32'h4);

      // success with scrubbed unlock and a start pulse mid-run (R4 R11)
      cfg(0, 1, 0, 2, 0, 3, 0, 4); full_writes(); run(8);
      ends("R11 busy start ignored", 3'b100, 3'd0, 32'h4);

      // R3 boot ROM reports unexpected status
      cfg(1, 5, 0, 1, 0, 3, 0, 4); push_wr(8'h00, img); run(0);
      ends("R3 bad boot status", 3'b010, 3'd1, 32'h5);

      // R8 boot ROM never answers
      cfg(1000000, 1, 0, 1, 0, 3, 0, 4); push_wr(8'h00, img); run(0);
      ends("R8 boot timeout", 3'b001, 3'd1, 32'h0);
      chk(cyc > LIM_BOOT, "R8 timeout not early", cyc, LIM_BOOT);
      chk(cyc <= LIM_BOOT + 20, "R8 timeout window", cyc, LIM_BOOT + 20);

      // R10 flags sticky while idle
      repeat (10) @(negedge clk);
      chk({done, err, tmo} == 3'b001 && fphase == 3'd1, "R10 sticky flags", {26'h0, done, err, tmo, fphase}, {26'h0, 3'b001, 3'd1});

      // R4 loader reports a bad value
      cfg(0, 1, 2, 3, 0, 3, 0, 4); push_wr(8'h00, img); run(0);
      ends("R4 bad loader status", 3'b010, 3'd2, 32'h3);

      // R6 negative status aborts metadata wait
      cfg(0, 1, 0, 1, 1, 32'h8000_0003, 0, 4); meta_writes(); run(0);
      ends("R6 negative metadata status", 3'b010, 3'd3, 32'h8000_0003);

      // R6 positive non-matching value keeps polling, then times out
      cfg(0, 1, 0, 1, 0, 2, 0, 4); meta_writes(); run(0);
      ends("R6 R8 metadata timeout", 3'b001, 3'd3, 32'h2);

      // R7 negative status in load phase
      cfg(0, 1, 0, 2, 0, 3, 2, 32'hFFFF_FFF0); full_writes(); run(0);
      ends("R7 negative load status", 3'b010, 3'd4, 32'hFFFF_FFF0);

      // R8 load phase never completes
      cfg(0, 1, 0, 1, 0, 3, 1000000, 4); full_writes(); run(0);
      ends("R8 load timeout", 3'b001, 3'd4, 32'h0);

      // new start after failure clears flags and succeeds (R2 R10)
      cfg(0, 1, 0, 1, 0, 3, 0, 4); full_writes(); run(0);
      ends("R2 restart after failure", 3'b100, 3'd0, 32'h4);

      summary_and_end();
   end
endmodule